// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is the target side of a four-wire host bus that loads a small bank of 4-bit configuration registers and reads one internal status flag back. The host clocks eight bits into the serial data input on rising edges of the bit clock. The first four bits are the register address and the last four are the value. Both fields are sent most significant bit first. The frame takes effect only when the host raises the separate write strobe. A second select line, active low, marks frames that belong to a different command path. While that line is low, a frame leaves the register bank untouched.

Once a frame has been committed, the host can re-apply the same value by pulsing the strobe again while keeping the bit clock high. This is useful for stepwise ramps. While the strobe is high and the select line is high, the block drives one status flag onto its data output. Register 2 picks the flag. Bit 0 of register 14 chooses which motor-stop threshold is reported. All four bus lines pass through two synchronising flip-flops into the system clock domain, and edges are detected there.

Top module: `ser_cfg_bank`

## Requirements
- R1: A synchronous active-high reset clears all fifteen registers to 0 and disables the data output driver.
- R2: A frame of eight bit-clock rising edges carries address bits then data bits, MSB first. It writes that data to that register (addresses 0 to 14) on the strobe rising edge. The register does not change before that edge, and no other register changes.
- R3: A strobe rising edge while the select line `servo_sel_n_i` is low changes no register.
- R4: A strobe rising edge that follows fewer than eight bits since the previous strobe edge changes no register.
- R5: Bits beyond the eighth in a frame are ignored, and the first eight bits are used.
- R6: A frame addressed to 15 changes no register.
- R7: Each further strobe pulse after a committed frame, with the bit clock held high, writes the same value to the same register again. A strobe pulse after an incomplete frame changes nothing.
- R8: `sda_oe_o` is high only while the synchronised strobe is high and the select line is high. It is therefore low while a frame is being shifted in. `sda_o` is 0 whenever the driver is off.
- R9: With the driver on, the value of register 2 selects the flag on `sda_o`: 0 subcode-ready (active low, passed as is), 1 speed at or above 75%, 2 speed at or above 50%, 3 motor stopped, 4 PLL lock, 5 the `aux_lvl_i` level. Any other value gives 0.
- R10: When register 14 bit 0 is 0, the motor-stopped code reports `stop12_i`. When that bit is 1, it reports `stop6_i`.
- R11: A write to register 2 and the rise of the output driver come from the same strobe edge and take effect in the same clock cycle. The first driven value already follows the new selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Serial bit clock from host |
| sda_i | input | 1 | Serial data from host |
| wstb_i | input | 1 | Write strobe, commits on rising edge |
| servo_sel_n_i | input | 1 | Low marks frames for the other command path |
| subq_rdy_n_i | input | 1 | Subcode word ready, active low |
| spd75_i | input | 1 | Motor at or above 75% speed |
| spd50_i | input | 1 | Motor at or above 50% speed |
| stop12_i | input | 1 | Motor at or below 12% speed |
| stop6_i | input | 1 | Motor at or below 6% speed |
| pll_lock_i | input | 1 | PLL locked |
| aux_lvl_i | input | 1 | External auxiliary level |
| cfg_o | output | NUM_REGS*DATA_W | Register contents, register i at bits i*DATA_W upward |
| sda_o | output | 1 | Status bit driven back to host |
| sda_oe_o | output | 1 | Output enable for `sda_o` |

## Verification
The commit of a frame into register 2 and the start of status readback are both triggered by one strobe rising edge. The first driven bit could therefore come from the old selection if the two paths were a cycle apart. The bench provokes this by rewriting register 2 from one flag code to another while the two flags hold opposite levels. It then samples `sda_o` on the very first cycle in which `sda_oe_o` is high and judges it against the newly selected flag. A bound property also ties every register change to a strobe rise seen three cycles earlier with the select line high.

// File: rtl/scfg_pkg.sv
package scfg_pkg;

    // Status selection codes held in the select register
    localparam int ST_SUBQ  = 0;
    localparam int ST_SPD75 = 1;
    localparam int ST_SPD50 = 2;
    localparam int ST_STOP  = 3;
    localparam int ST_LOCK  = 4;
    localparam int ST_AUX   = 5;

    // Bit positions inside the synchronised bus vector
    localparam int BUS_SCL  = 0;
    localparam int BUS_SDA  = 1;
    localparam int BUS_STB  = 2;
    localparam int BUS_GATE = 3;
    localparam int BUS_W    = 4;

    // Idle levels of the bus lines after reset
    localparam logic [BUS_W-1:0] BUS_IDLE = 4'b1011;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic stb_rise;
        logic stb_fall;
    } edge_t;

endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
    parameter int            W       = 4,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl_o
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) begin
                pipe_q[i] <= RST_VAL;
            end
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign lvl_o = pipe_q[STAGES-1];

endmodule

// File: rtl/scfg_frame_rx.sv
module scfg_frame_rx
    import scfg_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 4,
    parameter int NUM_REGS = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              stb_lvl,
    input  logic              gate_lvl,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              drive_en
);
    localparam int                FRAME_W = ADDR_W + DATA_W;
    localparam int                CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0]  FULL    = CNT_W'(FRAME_W);
    localparam logic [ADDR_W:0]   LIMIT   = (ADDR_W+1)'(NUM_REGS);

    typedef struct packed {
        logic [FRAME_W-1:0] shreg;
        logic [CNT_W-1:0]   cnt;
        logic               rpt_ok;
        logic [ADDR_W-1:0]  h_addr;
        logic [DATA_W-1:0]  h_data;
        logic               scl_p;
        logic               stb_p;
        logic               gate_p;
    } rx_t;

    rx_t   st_d, st_q;
    edge_t ev;

    logic [ADDR_W-1:0] f_addr;
    logic [DATA_W-1:0] f_data;
    logic              frame_full;
    logic              addr_ok;

    assign f_addr     = st_q.shreg[FRAME_W-1 -: ADDR_W];
    assign f_data     = st_q.shreg[DATA_W-1:0];
    assign frame_full = (st_q.cnt == FULL);
    assign addr_ok    = ({1'b0, f_addr} < LIMIT);

    always_comb begin
        ev.scl_rise = scl_lvl & ~st_q.scl_p;
        ev.scl_fall = ~scl_lvl & st_q.scl_p;
        ev.stb_rise = stb_lvl & ~st_q.stb_p;
        ev.stb_fall = ~stb_lvl & st_q.stb_p;
    end

    always_comb begin
        st_d        = st_q;
        st_d.scl_p  = scl_lvl;
        st_d.stb_p  = stb_lvl;
        st_d.gate_p = gate_lvl;
        wr_en       = 1'b0;
        wr_addr     = st_q.h_addr;
        wr_data     = st_q.h_data;

        // a clock low phase ends any repeat sequence
        if (ev.scl_fall) begin
            st_d.rpt_ok = 1'b0;
        end

        if (ev.stb_rise) begin
            st_d.cnt = '0;
            if (gate_lvl && frame_full && addr_ok) begin
                wr_en       = 1'b1;
                wr_addr     = f_addr;
                wr_data     = f_data;
                st_d.h_addr = f_addr;
                st_d.h_data = f_data;
                st_d.rpt_ok = 1'b1;
            end else if (gate_lvl && (st_q.cnt == '0) && st_q.rpt_ok && !ev.scl_fall) begin
                wr_en = 1'b1;
            end else begin
                st_d.rpt_ok = 1'b0;
            end
        end else if (ev.stb_fall) begin
            st_d.cnt = '0;
        end else if (ev.scl_rise && !frame_full) begin
            st_d.shreg = {st_q.shreg[FRAME_W-2:0], sda_lvl};
            st_d.cnt   = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= '0;
            st_q.scl_p  <= BUS_IDLE[BUS_SCL];
            st_q.stb_p  <= BUS_IDLE[BUS_STB];
            st_q.gate_p <= BUS_IDLE[BUS_GATE];
        end else begin
            st_q <= st_d;
        end
    end

    assign drive_en = st_q.stb_p & st_q.gate_p;

endmodule

// File: rtl/scfg_reg_bank.sv
module scfg_reg_bank #(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 4,
    parameter int NUM_REGS = 15
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [NUM_REGS*DATA_W-1:0]   regs_o
);
    logic [NUM_REGS-1:0]             hit;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_d, regs_q;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        assign hit[g]    = wr_en && (wr_addr == ADDR_W'(g));
        assign regs_d[g] = hit[g] ? wr_data : regs_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs_o = regs_q;

endmodule

// File: rtl/scfg_stat_mux.sv
module scfg_stat_mux
    import scfg_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic [DATA_W-1:0] sel,
    input  logic              slow_stop,
    input  logic              drive_en,
    input  logic              subq_rdy_n,
    input  logic              spd75,
    input  logic              spd50,
    input  logic              stop12,
    input  logic              stop6,
    input  logic              lock,
    input  logic              aux,
    output logic              sda_o,
    output logic              oe_o
);
    logic pick;

    always_comb begin
        case (int'(sel))
            ST_SUBQ:  pick = subq_rdy_n;
            ST_SPD75: pick = spd75;
            ST_SPD50: pick = spd50;
            ST_STOP:  pick = slow_stop ? stop6 : stop12;
            ST_LOCK:  pick = lock;
            ST_AUX:   pick = aux;
            default:  pick = 1'b0;
        endcase
        oe_o  = drive_en;
        sda_o = drive_en & pick;
    end

endmodule

// File: rtl/ser_cfg_bank.sv
module ser_cfg_bank
    import scfg_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 4,
    parameter int NUM_REGS    = 15,
    parameter int SEL_REG     = 2,
    parameter int MODE_REG    = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       scl_i,
    input  logic                       sda_i,
    input  logic                       wstb_i,
    input  logic                       servo_sel_n_i,
    input  logic                       subq_rdy_n_i,
    input  logic                       spd75_i,
    input  logic                       spd50_i,
    input  logic                       stop12_i,
    input  logic                       stop6_i,
    input  logic                       pll_lock_i,
    input  logic                       aux_lvl_i,
    output logic [NUM_REGS*DATA_W-1:0] cfg_o,
    output logic                       sda_o,
    output logic                       sda_oe_o
);
    logic [BUS_W-1:0]  bus_raw, bus_lvl;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              drive_en;
    logic [DATA_W-1:0] sel_val;
    logic [DATA_W-1:0] mode_val;

    always_comb begin
        bus_raw           = '0;
        bus_raw[BUS_SCL]  = scl_i;
        bus_raw[BUS_SDA]  = sda_i;
        bus_raw[BUS_STB]  = wstb_i;
        bus_raw[BUS_GATE] = servo_sel_n_i;
    end

    scfg_sync #(
        .W       (BUS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (BUS_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .din   (bus_raw),
        .lvl_o (bus_lvl)
    );

    scfg_frame_rx #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS)
    ) u_rx (
        .clk      (clk),
        .rst      (rst),
        .scl_lvl  (bus_lvl[BUS_SCL]),
        .sda_lvl  (bus_lvl[BUS_SDA]),
        .stb_lvl  (bus_lvl[BUS_STB]),
        .gate_lvl (bus_lvl[BUS_GATE]),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .drive_en (drive_en)
    );

    scfg_reg_bank #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .regs_o  (cfg_o)
    );

    assign sel_val  = cfg_o[SEL_REG*DATA_W +: DATA_W];
    assign mode_val = cfg_o[MODE_REG*DATA_W +: DATA_W];

    scfg_stat_mux #(
        .DATA_W (DATA_W)
    ) u_mux (
        .sel        (sel_val),
        .slow_stop  (mode_val[0]),
        .drive_en   (drive_en),
        .subq_rdy_n (subq_rdy_n_i),
        .spd75      (spd75_i),
        .spd50      (spd50_i),
        .stop12     (stop12_i),
        .stop6      (stop6_i),
        .lock       (pll_lock_i),
        .aux        (aux_lvl_i),
        .sda_o      (sda_o),
        .oe_o       (sda_oe_o)
    );

endmodule

// File: rtl/scfg_chk.sv
module scfg_chk #(
    parameter int DATA_W   = 4,
    parameter int NUM_REGS = 15,
    parameter int SEL_REG  = 2,
    parameter int MODE_REG = 14
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       wstb_i,
    input logic                       servo_sel_n_i,
    input logic                       stop12_i,
    input logic                       stop6_i,
    input logic                       aux_lvl_i,
    input logic [NUM_REGS*DATA_W-1:0] cfg_o,
    input logic                       sda_o,
    input logic                       sda_oe_o
);
    logic [2:0]                 age;
    logic [NUM_REGS*DATA_W-1:0] cfg_prev;
    logic [NUM_REGS-1:0]        chg;
    logic [DATA_W-1:0]          sel;
    logic                       slow;

    always_ff @(posedge clk) begin
        if (rst) begin
            age      <= '0;
            cfg_prev <= '0;
        end else begin
            if (age != 3'd7) age <= age + 3'd1;
            cfg_prev <= cfg_o;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            chg[i] = (cfg_o[i*DATA_W +: DATA_W] != cfg_prev[i*DATA_W +: DATA_W]);
        end
    end

    assign sel  = cfg_o[SEL_REG*DATA_W +: DATA_W];
    assign slow = cfg_o[MODE_REG*DATA_W];

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_o == '0) && !sda_oe_o);

    // R2
    single_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 3'd1) |-> ($countones(chg) <= 1));

    // R3
    commit_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ((age >= 3'd5) && (chg != '0)) |->
            ($past(wstb_i, 3) && !$past(wstb_i, 4) && $past(servo_sel_n_i, 3)));

    // R8
    drive_window_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 3'd4) |-> (sda_oe_o == ($past(wstb_i, 3) && $past(servo_sel_n_i, 3))));

    // R8
    quiet_line_chk: assert property (@(posedge clk) disable iff (rst)
        !sda_oe_o |-> !sda_o);

    // R10
    stop_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (sda_oe_o && (int'(sel) == 3) && slow) |-> (sda_o == stop6_i));

    // R9
    aux_path_chk: assert property (@(posedge clk) disable iff (rst)
        (sda_oe_o && (int'(sel) == 5)) |-> (sda_o == aux_lvl_i));

endmodule

bind ser_cfg_bank scfg_chk #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .SEL_REG  (SEL_REG),
    .MODE_REG (MODE_REG)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .wstb_i        (wstb_i),
    .servo_sel_n_i (servo_sel_n_i),
    .stop12_i      (stop12_i),
    .stop6_i       (stop6_i),
    .aux_lvl_i     (aux_lvl_i),
    .cfg_o         (cfg_o),
    .sda_o         (sda_o),
    .sda_oe_o      (sda_oe_o)
);

// File: tb/ser_cfg_bank_bench.sv
`timescale 1ns/1ps
module ser_cfg_bank_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1, sda = 1'b1, stb = 1'b0, seln = 1'b1;
    logic subq_n = 1'b1, s75 = 1'b0, s50 = 1'b0, st12 = 1'b0, st6 = 1'b0;
    logic lock = 1'b0, aux = 1'b0;
    logic [59:0] cfg;
    logic sda_o, oe;

    int total = 0, bad = 0, quiet = 0, cyc = 0;
    bit finished = 1'b0;
    int exp_r [15];

    always #2 clk = ~clk;

    ser_cfg_bank u_ser_cfg_bank (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda), .wstb_i(stb),
        .servo_sel_n_i(seln), .subq_rdy_n_i(subq_n), .spd75_i(s75),
        .spd50_i(s50), .stop12_i(st12), .stop6_i(st6), .pll_lock_i(lock),
        .aux_lvl_i(aux), .cfg_o(cfg), .sda_o(sda_o), .sda_oe_o(oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int regv(input int i);
        return int'(cfg[i*4 +: 4]);
    endfunction

    function automatic bit exp_sda();
        bit en;
        en = stb && seln;
        if (!en) return 1'b0;
        case (exp_r[2])
            0: return subq_n;
            1: return s75;
            2: return s50;
            3: return ((exp_r[14] & 1) != 0) ? st6 : st12;
            4: return lock;
            5: return aux;
            default: return 1'b0;
        endcase
    endfunction

    // behavioural model comparison on every settled clock
    always @(negedge clk) begin
        if (!rst && !finished && quiet >= 5) begin
            for (int i = 0; i < 15; i++) begin
                chk(regv(i) == exp_r[i], "R2 model register", regv(i), exp_r[i]);
            end
            chk(oe == (stb && seln), "R8 model enable", oe, int'(stb && seln));
            chk(sda_o == exp_sda(), "R9 model status", sda_o, exp_sda());
        end
    end

    always @(posedge clk) begin
        quiet++;
        cyc++;
        if (cyc == 100000 && !finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R1: actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic waitc(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic chk_all(input string req);
        @(negedge clk);
        for (int i = 0; i < 15; i++) begin
            chk(regv(i) == exp_r[i], req, regv(i), exp_r[i]);
        end
    endtask

    task automatic send(input int addr, input int data, input int nbits,
                        input bit gate, input bit pre_check);
        logic [15:0] w;
        bit drove;
        w = {addr[3:0], data[3:0], 8'b1010_0110};
        @(posedge clk); #1; seln = gate; quiet = 0;
        waitc(4);
        for (int b = 0; b < nbits; b++) begin
            @(posedge clk); #1; scl = 1'b0; sda = w[15-b]; quiet = 0;
            waitc(3);
            @(posedge clk); #1; scl = 1'b1; quiet = 0;
            waitc(3);
            if (b == 3) begin
                @(negedge clk);
                chk(oe == 1'b0, "R8 driver off while shifting", oe, 0);
            end
        end
        @(posedge clk); #1; sda = 1'b1; quiet = 0;
        if (pre_check) begin
            waitc(5);
            @(negedge clk);
            chk(regv(addr) == exp_r[addr], "R2 no change before strobe", regv(addr), exp_r[addr]);
        end
        @(posedge clk); #1; stb = 1'b1; quiet = 0;
        if (gate && nbits >= 8 && addr < 15) exp_r[addr] = data;
        drove = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (oe) begin drove = 1'b1; break; end
        end
        if (gate && nbits >= 8 && addr == 2) begin
            chk(drove, "R11 driver rose", drove, 1);
            chk(regv(2) == data, "R11 select updated with driver", regv(2), data);
            chk(sda_o == exp_sda(), "R11 first driven bit", sda_o, exp_sda());
        end
        waitc(6);
        @(posedge clk); #1; stb = 1'b0; quiet = 0;
        waitc(6);
        @(posedge clk); #1; seln = 1'b1; quiet = 0;
        waitc(6);
    endtask

    task automatic pulse(input string req);
        @(posedge clk); #1; stb = 1'b1; quiet = 0;
        waitc(6);
        @(negedge clk);
        chk(oe == (stb && seln), req, oe, int'(stb && seln));
        chk(sda_o == exp_sda(), req, sda_o, exp_sda());
        @(posedge clk); #1; stb = 1'b0; quiet = 0;
        waitc(6);
    endtask

    task automatic set_stat(input logic [6:0] p);
        @(posedge clk); #1;
        subq_n = p[0]; s75 = p[1]; s50 = p[2]; st12 = p[3];
        st6 = p[4]; lock = p[5]; aux = p[6];
        quiet = 0;
        waitc(2);
    endtask

    initial begin
        logic [6:0] pats [4];
        pats[0] = 7'b1010101; pats[1] = 7'b0101010;
        pats[2] = 7'b0011001; pats[3] = 7'b1100110;
        for (int i = 0; i < 15; i++) exp_r[i] = 0;
        waitc(5);
        @(posedge clk); #1; rst = 1'b0; quiet = 0;
        waitc(3);
        // R1 reset state
        chk_all("R1 reset value");
        chk(oe == 1'b0, "R1 driver off after reset", oe, 0);

        // R2 plain writes over several patterns
        send(3, 10, 8, 1'b1, 1'b1);
        chk_all("R2 write reg3");
        send(0, 5, 8, 1'b1, 1'b1);
        send(14, 0, 8, 1'b1, 1'b0);
        send(9, 15, 8, 1'b1, 1'b1);
        send(1, 6, 8, 1'b1, 1'b0);
        chk_all("R2 write several");

        // R3 servo path selected
        send(5, 7, 8, 1'b0, 1'b0);
        chk_all("R3 gated frame ignored");

        // R4 short frame
        send(4, 9, 5, 1'b1, 1'b0);
        chk_all("R4 short frame ignored");

        // R5 long frame keeps first eight bits
        send(6, 5, 10, 1'b1, 1'b0);
        chk(regv(6) == 5, "R5 long frame", regv(6), 5);

        // R6 address fifteen discarded
        send(15, 3, 8, 1'b1, 1'b0);
        chk_all("R6 address 15 discarded");

        // R7 repeat pulses
        send(7, 12, 8, 1'b1, 1'b0);
        for (int r = 0; r < 3; r++) pulse("R7 repeat pulse");
        chk_all("R7 repeat keeps value");
        send(8, 2, 3, 1'b1, 1'b0);
        pulse("R7 pulse after short frame");
        chk_all("R7 no stale commit");

        // R9 status selection across codes and patterns
        for (int s = 0; s < 7; s++) begin
            send(2, (s == 6) ? 9 : s, 8, 1'b1, 1'b0);
            for (int p = 0; p < 4; p++) begin
                set_stat(pats[p]);
                pulse("R9 status select");
            end
        end

        // R10 stop threshold mode
        send(2, 3, 8, 1'b1, 1'b0);
        set_stat(7'b0001000);
        send(14, 0, 8, 1'b1, 1'b0);
        pulse("R10 stop12 path");
        chk(sda_o == 1'b0, "R10 driver released", sda_o, 0);
        send(14, 1, 8, 1'b1, 1'b0);
        pulse("R10 stop6 path");
        set_stat(7'b0010000);
        pulse("R10 stop6 active");

        // R11 selection change lands with driver rise
        set_stat(7'b0100000);
        send(2, 1, 8, 1'b1, 1'b0);
        send(2, 4, 8, 1'b1, 1'b0);
        set_stat(7'b0000010);
        send(2, 1, 8, 1'b1, 1'b0);

        // R8 select line low blocks the driver
        @(posedge clk); #1; seln = 1'b0; quiet = 0;
        pulse("R8 driver off with select low");
        @(posedge clk); #1; seln = 1'b1; quiet = 0;
        waitc(6);
        chk_all("R8 registers untouched");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule